// File: doc/BRIEF.md
# Lockable Input Crossbar Selector

This block steers general-purpose input pins onto sixteen output channels. Each channel has its own 9-bit route code held in a register. The code names the pin that drives the channel, or it forces the channel to a constant level. The pin-to-channel path is purely combinational, so a pin change reaches its channel within the same cycle.

Software programs the route codes over a plain synchronous register port. The port has an address, a write strobe, write data and a combinational read data output. It is not a stream: it has no valid/ready handshake and never stalls, so back-pressure does not arise. Every write must coincide with an asserted write-permit input.

A separate set-only lock word can freeze any channel's route code. Once a lock bit is set, only a system reset clears it.

Top module: `inxbar_route`

## Requirements
- R1: After reset every route code reads 0x1FE, the lock word reads 0 and all sixteen channel outputs are 1.
- R2: Route code of channel c (c = 0..15) sits at word address c in data bits 8:0. Data bits 31:9 read 0, and their written values are discarded.
- R3: A route code below NUM_PINS drives the channel from the pin with that index.
- R4: Route code 0x1FF drives the channel to 0.
- R5: Every other route code at or above NUM_PINS, including 0x1FD and 0x1FE, drives the channel to 1.
- R6: The lock word is at address 0x1E. Bit k locks channel k (k = 0..15), and bits 31:16 read 0.
- R7: Writing a 1 to a lock bit sets it and writing a 0 leaves it unchanged. A set lock bit is cleared only by reset.
- R8: While the write-permit input is low, writes to the route codes and to the lock word change nothing.
- R9: A write to a locked channel's route code is discarded and that channel's output keeps following its old code. Reads of locked registers are still served.
- R10: Reads of addresses 0x10 to 0x1D and 0x1F return 0, and writes to them change no register.
- R11: A write takes effect at the rising clock edge that samples the strobe. Before that edge, the read data and channel outputs still show the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_permit | input | 1 | Write-permit enable; writes are accepted only while high |
| reg_addr | input | 5 | Register word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pin_in | input | NUM_PINS | General-purpose input pins |
| chan_out | output | 16 | Routed channel outputs |

## Verification
Read data and channel outputs are combinational from the stored registers and the pins. A register write therefore becomes visible right after the single clock edge that samples the strobe, and a pin change shows on its channel with no cycle delay.

The bench drives each write on a falling edge and samples results on the next falling edge, after exactly one rising edge. One test also samples just before that rising edge, to confirm that the old value still holds. Pin-driven checks are sampled a short delay after the pins change, within the same cycle.

Every one of the 512 codes is swept on all sixteen channels against two complementary pin patterns.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam int SEL_W     = 9;
  localparam int CHAN_N    = 16;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 5;
  localparam int IDX_W     = $clog2(CHAN_N);
  localparam int CODE_SPAN = 1 << SEL_W;

  localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(5'h1E);
  localparam logic [ADDR_W-1:0] CHAN_LIM  = ADDR_W'(CHAN_N);
  localparam logic [SEL_W-1:0]  CODE_ZERO = 9'h1FF;
  localparam logic [SEL_W-1:0]  CODE_RST  = 9'h1FE;

  typedef logic [SEL_W-1:0] code_t;
  typedef logic [CHAN_N-1:0][SEL_W-1:0] code_vec_t;
endpackage

// File: rtl/xbar_regfile.sv
module xbar_regfile
  import xbar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_permit,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output code_vec_t         code_q,
  output logic [CHAN_N-1:0] lock_q
);
  logic              wr_ok;
  logic              hit_code;
  logic              hit_lock;
  logic [IDX_W-1:0]  idx;

  assign wr_ok    = wr_en & wr_permit;
  assign hit_code = (addr < CHAN_LIM);
  assign hit_lock = (addr == LOCK_ADDR);
  assign idx      = addr[IDX_W-1:0];

  // Lock word: set-only, cleared by reset alone.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lock_q <= '0;
    else if (wr_ok && hit_lock)
      lock_q <= lock_q | wdata[CHAN_N-1:0];
  end

  // One route-code register per channel, each gated by its own lock bit.
  for (genvar c = 0; c < CHAN_N; c++) begin : g_code
    logic take;
    assign take = wr_ok & hit_code & (idx == IDX_W'(c)) & ~lock_q[c];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        code_q[c] <= CODE_RST;
      else if (take)
        code_q[c] <= wdata[SEL_W-1:0];
    end
  end
endmodule

// File: rtl/xbar_chan_mux.sv
module xbar_chan_mux
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  code_t               code,
  input  logic [NUM_PINS-1:0] pins,
  output logic                out
);
  // Pins padded with ones up to the full code space: codes past the
  // last pin land on a 1 without a separate range compare.
  logic [CODE_SPAN-1:0] padded;

  always_comb begin
    padded                 = '1;
    padded[NUM_PINS-1:0]   = pins;
  end

  assign out = (code == CODE_ZERO) ? 1'b0 : padded[code];
endmodule

// File: rtl/xbar_rd_mux.sv
module xbar_rd_mux
  import xbar_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  code_vec_t         code_q,
  input  logic [CHAN_N-1:0] lock_q,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (addr < CHAN_LIM)
      rdata[SEL_W-1:0] = code_q[addr[IDX_W-1:0]];
    else if (addr == LOCK_ADDR)
      rdata[CHAN_N-1:0] = lock_q;
  end
endmodule

// File: rtl/inxbar_route.sv
module inxbar_route
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_permit,
  input  logic [4:0]          reg_addr,
  input  logic                reg_we,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [15:0]         chan_out
);
  code_vec_t         code_q;
  logic [CHAN_N-1:0] lock_q;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:CHAN_N];

  xbar_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_permit (wr_permit),
    .wr_en     (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .code_q    (code_q),
    .lock_q    (lock_q)
  );

  xbar_rd_mux u_rd (
    .addr   (reg_addr),
    .code_q (code_q),
    .lock_q (lock_q),
    .rdata  (reg_rdata)
  );

  for (genvar c = 0; c < CHAN_N; c++) begin : g_chan
    xbar_chan_mux #(.NUM_PINS(NUM_PINS)) u_mux (
      .code (code_q[c]),
      .pins (pin_in),
      .out  (chan_out[c])
    );
  end
endmodule

// File: rtl/xbar_chk.sv
module xbar_chk
  import xbar_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_permit,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic                reg_we,
  input logic [DATA_W-1:0]   reg_rdata,
  input logic [CHAN_N-1:0]   chan_out,
  input code_vec_t           code_q,
  input logic [CHAN_N-1:0]   lock_q
);
  // R7: no lock bit ever falls while out of reset.
  assert_lock_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_q) & ~lock_q) == '0);

  // R8: without write permit, nothing stored moves.
  assert_no_permit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_permit |=> ($stable(code_q) && $stable(lock_q)));

  // R9: a write aimed at a locked channel leaves all route codes unchanged.
  assert_locked_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && wr_permit && (reg_addr < CHAN_LIM) && lock_q[reg_addr[IDX_W-1:0]])
      |=> $stable(code_q));

  // R2 / R6 / R10: read data has zeros outside its defined field.
  assert_rd_code_upper_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr < CHAN_LIM) |-> (reg_rdata[DATA_W-1:SEL_W] == '0));
  assert_rd_lock_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == LOCK_ADDR) |-> (reg_rdata[DATA_W-1:CHAN_N] == '0));
  assert_rd_hole_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_addr >= CHAN_LIM) && (reg_addr != LOCK_ADDR)) |-> (reg_rdata == '0));

  for (genvar c = 0; c < CHAN_N; c++) begin : g_out
    // R4: the zero code forces a 0.
    assert_const0_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q[c] == CODE_ZERO) |-> !chan_out[c]);
    // R5: other codes past the pins force a 1.
    assert_const1_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((code_q[c] != CODE_ZERO) && (32'(code_q[c]) >= NUM_PINS)) |-> chan_out[c]);
  end
endmodule

bind inxbar_route xbar_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_permit (wr_permit),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .reg_rdata (reg_rdata),
  .chan_out  (chan_out),
  .code_q    (code_q),
  .lock_q    (lock_q)
);

// File: tb/test_inxbar_route.sv
`timescale 1ns/1ps
module test_inxbar_route;
  localparam int P = 24;
  localparam logic [P-1:0] PAT_A = 24'hC35A96;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_permit = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [P-1:0]  pin_in = PAT_A;
  logic [15:0]   chan_out;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  inxbar_route #(.NUM_PINS(P)) i_inxbar_route (
    .clk(clk), .rst_n(rst_n), .wr_permit(wr_permit),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pin_in(pin_in), .chan_out(chan_out)
  );

  function automatic logic model_out(input int code, input logic [P-1:0] pins);
    if (code == 511) return 1'b0;
    if (code < P) return pins[code];
    return 1'b1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic permit);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1; wr_permit = permit;
    @(negedge clk);
    reg_we = 1'b0; wr_permit = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1: reset state
    for (int c = 0; c < 16; c++) begin rd(5'(c), v); chk("R1 code", v, 32'h1FE); end
    rd(5'h1E, v); chk("R1 lock", v, 32'h0);
    chk("R1 outputs", {16'h0, chan_out}, 32'h0000FFFF);

    // R11: not visible before the edge, visible right after it
    @(negedge clk);
    reg_addr = 5'd0; reg_wdata = 32'd5; reg_we = 1'b1; wr_permit = 1'b1;
    #1; chk("R11 before edge", reg_rdata, 32'h1FE);
    @(negedge clk);
    reg_we = 1'b0; wr_permit = 1'b0;
    #1; chk("R11 after edge", reg_rdata, 32'd5);

    // R2 R3 R4 R5: every code on every channel, two pin patterns
    for (int c = 0; c < 16; c++) begin
      for (int code = 0; code < 512; code++) begin
        pin_in = PAT_A;
        wr(5'(c), {23'h5A5A5A ^ 23'(code), 9'(code)}, 1'b1);
        rd(5'(c), v); chk("R2 readback", v, 32'(code));
        chk("R3/R4/R5 pattern A", {31'h0, chan_out[c]}, {31'h0, model_out(code, PAT_A)});
        pin_in = ~PAT_A; #1;
        chk("R3/R4/R5 pattern B", {31'h0, chan_out[c]}, {31'h0, model_out(code, ~PAT_A)});
      end
    end
    pin_in = PAT_A;

    // R8: writes without permit
    for (int c = 0; c < 16; c++) wr(5'(c), 32'd3, 1'b1);
    wr(5'd2, 32'd7, 1'b0);
    rd(5'd2, v); chk("R8 code unchanged", v, 32'd3);
    wr(5'h1E, 32'hFFFF, 1'b0);
    rd(5'h1E, v); chk("R8 lock unchanged", v, 32'h0);

    // R10: holes read 0 and absorb writes
    for (int a = 16; a < 32; a++) begin
      if (a != 30) begin
        wr(5'(a), 32'hFFFFFFFF, 1'b1);
        rd(5'(a), v); chk("R10 hole read", v, 32'h0);
      end
    end
    for (int c = 0; c < 16; c++) begin rd(5'(c), v); chk("R10 codes intact", v, 32'd3); end
    rd(5'h1E, v); chk("R10 lock intact", v, 32'h0);

    // R6: lock bits 0 and 2, upper half discarded
    wr(5'h1E, 32'hFFFF0005, 1'b1);
    rd(5'h1E, v); chk("R6 lock word", v, 32'h5);

    // R9: locked channels keep their code and routing
    wr(5'd0, 32'd9, 1'b1);
    rd(5'd0, v); chk("R9 locked ch0 code", v, 32'd3);
    chk("R9 locked ch0 out", {31'h0, chan_out[0]}, {31'h0, PAT_A[3]});
    wr(5'd2, 32'h1FF, 1'b1);
    rd(5'd2, v); chk("R9 locked ch2 code", v, 32'd3);
    wr(5'd1, 32'd9, 1'b1);
    rd(5'd1, v); chk("R6 unlocked ch1 code", v, 32'd9);
    chk("R6 unlocked ch1 out", {31'h0, chan_out[1]}, {31'h0, PAT_A[9]});

    // R7: zero writes keep bits, ones add bits, reset clears
    wr(5'h1E, 32'h0, 1'b1);
    rd(5'h1E, v); chk("R7 zero write", v, 32'h5);
    wr(5'h1E, 32'h8000, 1'b1);
    rd(5'h1E, v); chk("R7 set more", v, 32'h8005);
    do_reset();
    rd(5'h1E, v); chk("R7 reset clears", v, 32'h0);
    rd(5'd0, v); chk("R1 code after reset", v, 32'h1FE);
    chk("R1 outputs after reset", {16'h0, chan_out}, 32'h0000FFFF);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule